// File: doc/BRIEF.md
# Credit-Gated Row Streaming Unit

This unit feeds one row of processing elements in a mesh accelerator from a shared global buffer. It uses a dedicated streaming bus that bypasses the mesh routers. Two ready/valid sources reach it from the buffer side: an activation stream and a weight stream. Every word it accepts goes to all nodes of the row at once. It appears on the bus for exactly one cycle, starting in the cycle after the handshake.

The nodes do not signal back through any flow-control wires. Instead, the unit keeps a free-slot count for the incoming queue of each node's network interface. A node sends a one-cycle credit-return pulse each time it dequeues a word. A word is released only when every node in the row has room for it.

A mode input selects between two layouts:
- **Two-way:** activations and weights travel on separate links.
- **One-way:** both streams share one link through a multiplexer. A tag bit marks weights, and the two streams alternate whenever both have data.

A preload option holds activations back until the final weight of a batch has been sent. This suits dataflows that need the weights loaded first.

Top module: `row_stream_unit`

## Requirements
- R1: After reset, both bus links are idle (`lnk0_valid`=0, `lnk1_valid`=0), and every node is counted as having QDEPTH free slots (default 4). A source with valid data is therefore ready at once.
- R2: With `two_way`=1, activations leave on link 0 with `lnk0_is_wt`=0, and weights leave on link 1. Each word appears on its link in the cycle after its handshake. Both streams may be accepted in the same cycle.
- R3: With `two_way`=0, both streams leave on link 0. `lnk0_is_wt` is 1 for a weight and 0 for an activation, and link 1 stays idle.
- R4: With `two_way`=0 and both sources valid, the link alternates between activation and weight words. The first word after reset is an activation.
- R5: With `two_way`=0 and only one source valid, that source is accepted on every cycle in which credits allow, with no idle cycle inserted for alternation.
- R6: A word is accepted only if every node has at least one free slot. In two-way mode, two words in one cycle need two free slots at every node. When only one slot is free, the weight goes first.
- R7: A credit-return pulse on bit i of `credit_ret` frees one slot for node i. Returns that would push a node above QDEPTH free slots are dropped.
- R8: While `wt_first`=1, activations are not accepted until a weight with `wt_last`=1 has been accepted since reset. This holds in both modes.
- R9: Each accepted word produces exactly one bus cycle with its data. No bus cycle appears without an accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_way | input | 1 | 1: separate links; 0: shared, interleaved link |
| wt_first | input | 1 | Hold activations until the final weight has gone |
| act_valid | input | 1 | Activation word available |
| act_data | input | DATA_W | Activation word |
| act_ready | output | 1 | Activation word accepted this cycle when valid |
| wt_valid | input | 1 | Weight word available |
| wt_data | input | DATA_W | Weight word |
| wt_last | input | 1 | Marks the final weight of a preload batch |
| wt_ready | output | 1 | Weight word accepted this cycle when valid |
| credit_ret | input | NODES | Per-node one-cycle dequeue pulse |
| lnk0_valid | output | 1 | Link 0 carries a word this cycle |
| lnk0_data | output | DATA_W | Link 0 word |
| lnk0_is_wt | output | 1 | Link 0 word is a weight |
| lnk1_valid | output | 1 | Link 1 carries a weight (two-way only) |
| lnk1_data | output | DATA_W | Link 1 word |

## Verification
The tests compare runs in each mode:
- Both sources held valid in two-way mode shows that the links are independent.
- The same traffic in one-way mode checks the tag and the alternation order.
- A lone activation source in one-way mode shows that no cycle is wasted on alternation.
- With credit returns switched off, a queue depth's worth of words fills the nodes. Returning credits to all nodes but one shows that a single full node blocks the whole row.
- Extra returns sent right after reset check saturation.
- The preload option is tried in both modes to confirm that no activation overtakes the final weight.

// File: rtl/row_stream_unit.sv
module row_stream_unit #(
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_way,
  input  logic              wt_first,
  input  logic              act_valid,
  input  logic [DATA_W-1:0] act_data,
  output logic              act_ready,
  input  logic              wt_valid,
  input  logic [DATA_W-1:0] wt_data,
  input  logic              wt_last,
  output logic              wt_ready,
  input  logic [NODES-1:0]  credit_ret,
  output logic              lnk0_valid,
  output logic [DATA_W-1:0] lnk0_data,
  output logic              lnk0_is_wt,
  output logic              lnk1_valid,
  output logic [DATA_W-1:0] lnk1_data
);
  localparam int CW = $clog2(QDEPTH + 1) + 2;
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic [CW-1:0] free_q [NODES];
  logic [NODES-1:0] has1, has2;
  logic ok1, ok2, pre_done, last_wt, act_en;
  logic act_fire, wt_fire;
  logic [1:0] nsent;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    logic [CW-1:0] sum;
    assign has1[i] = free_q[i] >= CW'(1);
    assign has2[i] = free_q[i] >= CW'(2);
    assign sum = free_q[i] - CW'(nsent) + CW'(credit_ret[i]);
    always_ff @(posedge clk) begin
      if (!rst_n)          free_q[i] <= FULL;
      else if (sum > FULL) free_q[i] <= FULL;
      else                 free_q[i] <= sum;
    end
  end

  assign ok1    = &has1;
  assign ok2    = &has2;
  assign act_en = !(wt_first && !pre_done);

  always_comb begin
    if (two_way) begin
      wt_ready  = ok1;
      act_ready = act_en && (wt_valid ? ok2 : ok1);
    end else begin
      wt_ready  = ok1 && (!(act_valid && act_en) || !last_wt);
      act_ready = ok1 && act_en && (!wt_valid || last_wt);
    end
  end

  assign act_fire = act_valid && act_ready;
  assign wt_fire  = wt_valid && wt_ready;
  assign nsent    = {1'b0, act_fire} + {1'b0, wt_fire};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_done   <= 1'b0;
      last_wt    <= 1'b1;
      lnk0_valid <= 1'b0;
      lnk0_data  <= '0;
      lnk0_is_wt <= 1'b0;
      lnk1_valid <= 1'b0;
      lnk1_data  <= '0;
    end else begin
      if (wt_fire && wt_last) pre_done <= 1'b1;
      if (!two_way && (act_fire || wt_fire)) last_wt <= wt_fire;
      lnk0_valid <= act_fire || (!two_way && wt_fire);
      lnk0_data  <= act_fire ? act_data : wt_data;
      lnk0_is_wt <= !two_way && wt_fire;
      lnk1_valid <= two_way && wt_fire;
      lnk1_data  <= wt_data;
    end
  end
endmodule

// File: rtl/row_stream_unit_chk.sv
module row_stream_unit_chk #(
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  parameter int QDEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              two_way,
  input logic              wt_first,
  input logic              act_valid,
  input logic [DATA_W-1:0] act_data,
  input logic              act_ready,
  input logic              wt_valid,
  input logic [DATA_W-1:0] wt_data,
  input logic              wt_last,
  input logic              wt_ready,
  input logic [NODES-1:0]  credit_ret,
  input logic              lnk0_valid,
  input logic [DATA_W-1:0] lnk0_data,
  input logic              lnk0_is_wt,
  input logic              lnk1_valid,
  input logic [DATA_W-1:0] lnk1_data
);
  localparam int SW = $clog2(QDEPTH + 1) + 3;
  logic seen_last;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_last <= 1'b0;
    else if (wt_valid && wt_ready && wt_last) seen_last <= 1'b1;
  end

  for (genvar i = 0; i < NODES; i++) begin : g_shadow
    logic [SW-1:0] held, grown;
    assign grown = held + SW'(lnk0_valid) + SW'(lnk1_valid);
    always_ff @(posedge clk) begin
      if (!rst_n) held <= '0;
      else if (credit_ret[i] && grown != '0) held <= grown - SW'(1);
      else held <= grown;
    end
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      held <= SW'(QDEPTH)); // R6
  end

  AST_ACT_ON_LINK0: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ready) |=> (lnk0_valid && !lnk0_is_wt && lnk0_data == $past(act_data))); // R2

  AST_WT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_valid && wt_ready) |=> ($past(two_way) ? (lnk1_valid && lnk1_data == $past(wt_data))
                                               : (lnk0_valid && lnk0_is_wt && lnk0_data == $past(wt_data)))); // R3

  AST_SHARED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_way && act_valid && wt_valid) |-> !(act_ready && wt_ready)); // R4

  AST_LINK1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lnk1_valid |-> $past(two_way)); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    lnk0_valid |-> $past(act_valid && act_ready) || $past(wt_valid && wt_ready)); // R9

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_first && !seen_last) |-> !act_ready); // R8
endmodule

bind row_stream_unit row_stream_unit_chk #(.NODES(NODES), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .two_way(two_way), .wt_first(wt_first),
  .act_valid(act_valid), .act_data(act_data), .act_ready(act_ready),
  .wt_valid(wt_valid), .wt_data(wt_data), .wt_last(wt_last), .wt_ready(wt_ready),
  .credit_ret(credit_ret), .lnk0_valid(lnk0_valid), .lnk0_data(lnk0_data),
  .lnk0_is_wt(lnk0_is_wt), .lnk1_valid(lnk1_valid), .lnk1_data(lnk1_data));

// File: tb/row_stream_unit_test.sv
module row_stream_unit_test;
  localparam int NODES = 4, DATA_W = 16, QDEPTH = 4;

  logic clk = 0, rst_n = 0, two_way = 0, wt_first = 0;
  logic act_valid = 0, wt_valid = 0, wt_last = 0;
  logic [DATA_W-1:0] act_data = '0, wt_data = '0;
  logic act_ready, wt_ready;
  logic [NODES-1:0] credit_ret = '0;
  logic lnk0_valid, lnk0_is_wt, lnk1_valid;
  logic [DATA_W-1:0] lnk0_data, lnk1_data;

  row_stream_unit #(.NODES(NODES), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .two_way(two_way), .wt_first(wt_first),
    .act_valid(act_valid), .act_data(act_data), .act_ready(act_ready),
    .wt_valid(wt_valid), .wt_data(wt_data), .wt_last(wt_last), .wt_ready(wt_ready),
    .credit_ret(credit_ret), .lnk0_valid(lnk0_valid), .lnk0_data(lnk0_data),
    .lnk0_is_wt(lnk0_is_wt), .lnk1_valid(lnk1_valid), .lnk1_data(lnk1_data));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [DATA_W:0] exp0[$];
  logic [DATA_W-1:0] exp1[$];
  string req0[$], req1[$];
  bit auto_ret = 1;
  int pend = 0, seen = 0, lnk1_seen = 0, cyc = 0;
  int first_cyc = -1, last_cyc = -1, first_act_cyc = -1, last_wt_cyc = -1;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (lnk0_valid) begin
        seen++; pend++;
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        if (lnk0_is_wt) last_wt_cyc = cyc;
        else if (first_act_cyc < 0) first_act_cyc = cyc;
        if (exp0.size() == 0) check(0, "R9", "unexpected link0 word", int'(lnk0_data), 0);
        else begin
          logic [DATA_W:0] e; string r;
          e = exp0.pop_front(); r = req0.pop_front();
          check({lnk0_is_wt, lnk0_data} == e, r, "link0 tag/data", int'({lnk0_is_wt, lnk0_data}), int'(e));
        end
      end
      if (lnk1_valid) begin
        seen++; pend++; lnk1_seen++;
        last_wt_cyc = cyc;
        if (exp1.size() == 0) check(0, "R9", "unexpected link1 word", int'(lnk1_data), 0);
        else begin
          logic [DATA_W-1:0] e; string r;
          e = exp1.pop_front(); r = req1.pop_front();
          check(lnk1_data == e, r, "link1 data", int'(lnk1_data), int'(e));
        end
      end
    end
    if (auto_ret) begin
      if (pend > 0) begin credit_ret = '1; pend--; end
      else credit_ret = '0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; act_valid = 0; wt_valid = 0; wt_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    pend = 0; seen = 0; lnk1_seen = 0;
    first_cyc = -1; last_cyc = -1; first_act_cyc = -1; last_wt_cyc = -1;
  endtask

  task automatic drive(bit is_wt, int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (is_wt) begin wt_valid = 1; wt_data = DATA_W'(base + i); wt_last = (i == n - 1); end
      else begin act_valid = 1; act_data = DATA_W'(base + i); end
      #1;
      while (!(is_wt ? wt_ready : act_ready)) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    if (is_wt) begin wt_valid = 0; wt_last = 0; end else act_valid = 0;
  endtask

  task automatic plan_word(bit lnk1, bit is_wt, int d, string r);
    if (lnk1) begin exp1.push_back(DATA_W'(d)); req1.push_back(r); end
    else begin exp0.push_back({is_wt, DATA_W'(d)}); req0.push_back(r); end
  endtask

  task automatic pulse(logic [NODES-1:0] m);
    @(negedge clk); credit_ret = m;
    @(negedge clk); credit_ret = '0;
  endtask

  task automatic settle(string r);
    repeat (10) @(negedge clk);
    check(exp0.size() == 0 && exp1.size() == 0, r, "words still expected", exp0.size() + exp1.size(), 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    do_reset();
    #1;
    check(!lnk0_valid && !lnk1_valid, "R1", "links idle after reset", {lnk0_valid, lnk1_valid}, 0);
    act_valid = 1; wt_valid = 1; two_way = 0; #1;
    check(act_ready, "R1", "activation ready with full credits", act_ready, 1);
    act_valid = 0; wt_valid = 0;

    // R2 two-way: separate links, concurrent streams
    do_reset(); two_way = 1;
    for (int i = 0; i < 5; i++) begin
      plan_word(0, 0, 'h1000 + i, "R2");
      plan_word(1, 1, 'h2000 + i, "R2");
    end
    fork drive(0, 5, 'h1000); drive(1, 5, 'h2000); join
    settle("R2");

    // R3/R4 one-way: shared link, alternating, activation first
    do_reset(); two_way = 0;
    for (int i = 0; i < 6; i++) begin
      if (i < 6) plan_word(0, 0, 'h1100 + i, "R4");
      if (i < 3) plan_word(0, 1, 'h2100 + i, "R3");
    end
    exp0.delete(); req0.delete();
    for (int i = 0; i < 3; i++) begin
      plan_word(0, 0, 'h1100 + i, "R4"); plan_word(0, 1, 'h2100 + i, "R3");
    end
    for (int i = 3; i < 6; i++) plan_word(0, 0, 'h1100 + i, "R5");
    fork drive(0, 6, 'h1100); drive(1, 3, 'h2100); join
    settle("R4");
    check(lnk1_seen == 0, "R3", "link1 used in one-way mode", lnk1_seen, 0);

    // R5: lone stream back-to-back
    do_reset(); two_way = 0;
    for (int i = 0; i < 5; i++) plan_word(0, 0, 'h1200 + i, "R5");
    drive(0, 5, 'h1200);
    settle("R5");
    check(last_cyc - first_cyc == 4, "R5", "cycles across 5 lone words", last_cyc - first_cyc, 4);

    // R6: credit exhaustion blocks the whole row
    do_reset(); two_way = 0; auto_ret = 0;
    for (int i = 0; i < 6; i++) plan_word(0, 0, 'h1300 + i, "R6");
    fork drive(0, 6, 'h1300); join_none
    repeat (20) @(negedge clk);
    check(seen == QDEPTH, "R6", "words before credits run out", seen, QDEPTH);
    pulse({1'b0, {(NODES-1){1'b1}}});
    repeat (5) @(negedge clk);
    check(seen == QDEPTH, "R6", "one full node still blocks", seen, QDEPTH);
    pulse({1'b1, {(NODES-1){1'b0}}});
    repeat (5) @(negedge clk);
    check(seen == QDEPTH + 1, "R7", "credit return frees one slot", seen, QDEPTH + 1);
    pend = QDEPTH; auto_ret = 1;
    wait (seen == 6);
    settle("R6");

    // R7: returns beyond full are dropped
    do_reset(); auto_ret = 0;
    repeat (3) pulse('1);
    for (int i = 0; i < 6; i++) plan_word(0, 0, 'h1400 + i, "R7");
    fork drive(0, 6, 'h1400); join_none
    repeat (20) @(negedge clk);
    check(seen == QDEPTH, "R7", "saturated credit count", seen, QDEPTH);
    pend = QDEPTH; auto_ret = 1;
    wait (seen == 6);
    settle("R7");

    // R8 one-way preload: all weights before activations
    do_reset(); two_way = 0; wt_first = 1;
    for (int i = 0; i < 3; i++) plan_word(0, 1, 'h2500 + i, "R8");
    for (int i = 0; i < 3; i++) plan_word(0, 0, 'h1500 + i, "R8");
    fork drive(0, 3, 'h1500); drive(1, 3, 'h2500); join
    settle("R8");

    // R8 two-way preload
    do_reset(); two_way = 1; wt_first = 1;
    for (int i = 0; i < 3; i++) plan_word(1, 1, 'h2600 + i, "R8");
    for (int i = 0; i < 3; i++) plan_word(0, 0, 'h1600 + i, "R8");
    fork drive(0, 3, 'h1600); drive(1, 3, 'h2600); join
    settle("R8");
    check(first_act_cyc > last_wt_cyc, "R8", "first activation cycle after last weight", first_act_cyc, last_wt_cyc + 1);
    wt_first = 0;

    done = 1;
    summary();
  end
endmodule